// File: doc/BRIEF.md
# Page Write Buffer With Timed Commit

This block gathers the data bytes of one serial-memory write transaction into a page latch of `PAGE_BYTES` slots. Each slot has its own valid bit. A transaction opens when a word address is loaded. Each received byte goes to the slot named by the low address bits, and only those low bits advance after each byte. The page number, held in the upper bits, stays fixed. Past the last slot of the page, the pointer wraps to slot 0 of the same page, so extra bytes overwrite earlier ones.

When a stop event closes an open transaction, the block commits the page. It walks the slots in ascending order, one per cycle. For each slot that holds a received byte, it presents the slot's array address and data. The array write strobe fires only if the protect logic's per-address enable allows that address. After the walk, a timer holds the busy flag for `WR_CYCLES` further clocks. The busy period is applied in full even when every byte was blocked. While busy, the block ignores all transaction inputs.

A start event before the stop discards the buffered bytes, and nothing is committed. The serial protocol and the protect decision are made outside this block.

Top module: `pwb_page_writer`

## Requirements
- R1: After reset, `busy_o` and `mem_we_o` are low and no write strobe occurs until a transaction is committed.
- R2: The k-th data byte (k from 0) after an address load A goes to address {A[7:4], (A[3:0]+k) mod 16}, with its own data value.
- R3: Writing more than 16 bytes wraps within the page. The last byte received for a slot is the one written, and no address outside page A[7:4] is strobed.
- R4: Only slots that received a byte in the transaction are written (partial page). The strobe count equals the number of distinct slots received, less those that are protected.
- R5: Write strobes occur only while `busy_o` is high, in strictly ascending slot order, at most one per slot.
- R6: A stop that ends an open transaction raises `busy_o` at the next clock. `busy_o` then stays high for exactly `PAGE_BYTES + WR_CYCLES` cycles, including when zero bytes were sent.
- R7: A byte whose address has `wr_allow_i` low during its commit cycle is not strobed, and the busy period keeps its full length.
- R8: A start event after an address load and before the stop discards the transaction. The following stop then produces no busy period and no strobes.
- R9: While `busy_o` is high, start, address-load, byte and stop inputs have no effect. The committed data is unchanged, and no second busy period follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start event pulse; discards an open transaction |
| addr_load_i | input | 1 | Word address strobe; opens a transaction |
| addr_i | input | ADDR_W | Starting word address |
| byte_vld_i | input | 1 | Data byte strobe |
| byte_i | input | DATA_W | Data byte |
| stop_i | input | 1 | Stop event pulse; commits an open transaction |
| wr_allow_i | input | 1 | Protect logic enable for the address on `mem_addr_o` |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_data_o | output | DATA_W | Array write data |
| busy_o | output | 1 | Write cycle in progress; inputs ignored |

## Verification
Several rules are checked by assertions on every cycle: strobes appear only inside the busy window, the commit walk advances one slot per cycle, the hold timer never passes its limit, a busy period always lasts more than one cycle, and the page number is frozen during busy. The bench scenarios cover the rest. These are the address arithmetic and the wrap overwrite, partial-page selection, the protect filter with its full-length busy period, the exact busy length, discard on start, and the inputs ignored during busy. Each is judged by comparing a bench memory model, filled from the strobes, against values computed from the requirements.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_COMMIT = 2'd1,
        SEQ_HOLD   = 2'd2
    } seq_state_e;
endpackage

// File: rtl/pwb_page_latch.sv
module pwb_page_latch #(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 16,
    localparam int SLOT_W    = $clog2(PAGE_BYTES),
    localparam int PAGE_W    = ADDR_W - SLOT_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clr_i,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              close_i,
    input  logic [SLOT_W-1:0] rd_idx_i,
    output logic [PAGE_W-1:0] page_o,
    output logic              open_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_vld_o
);
    typedef struct packed {
        logic [PAGE_W-1:0]                      page;
        logic [SLOT_W-1:0]                      ptr;
        logic                                   open;
        logic [PAGE_BYTES-1:0]                  vld;
        logic [PAGE_BYTES-1:0][DATA_W-1:0]      data;
    } lat_t;

    lat_t lat_d, lat_q;

    always_comb begin
        lat_d = lat_q;
        if (clr_i) begin
            lat_d.open = 1'b0;
            lat_d.vld  = '0;
        end else begin
            if (load_i) begin
                lat_d.page = addr_i[ADDR_W-1:SLOT_W];
                lat_d.ptr  = addr_i[SLOT_W-1:0];
                lat_d.open = 1'b1;
                lat_d.vld  = '0;
            end else if (wr_i && lat_q.open) begin
                lat_d.data[lat_q.ptr] = data_i;
                lat_d.vld[lat_q.ptr]  = 1'b1;
                lat_d.ptr             = lat_q.ptr + 1'b1;
            end
            if (close_i) begin
                lat_d.open = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lat_q <= '0;
        end else begin
            lat_q <= lat_d;
        end
    end

    assign page_o    = lat_q.page;
    assign open_o    = lat_q.open;
    assign rd_data_o = lat_q.data[rd_idx_i];
    assign rd_vld_o  = lat_q.vld[rd_idx_i];

    // R3: page number never moves while a transaction stays open
    a_r3_page_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lat_q.open && $past(lat_q.open) && !$past(load_i)) |-> $stable(lat_q.page));

    // R8: a clear leaves no valid slot and no open transaction
    a_r8_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(clr_i) |-> (lat_q.vld == '0 && !lat_q.open));
endmodule

// File: rtl/pwb_commit_seq.sv
module pwb_commit_seq
    import pwb_pkg::*;
#(
    parameter int PAGE_BYTES = 16,
    parameter int WR_CYCLES  = 500000,
    localparam int SLOT_W    = $clog2(PAGE_BYTES),
    localparam int CNT_W     = $clog2(WR_CYCLES + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              go_i,
    output logic [SLOT_W-1:0] idx_o,
    output logic              commit_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(PAGE_BYTES - 1);
    localparam logic [CNT_W-1:0]  LAST_CNT  = CNT_W'(WR_CYCLES - 1);

    typedef struct packed {
        seq_state_e        st;
        logic [SLOT_W-1:0] idx;
        logic [CNT_W-1:0]  cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            SEQ_IDLE: begin
                if (go_i) begin
                    seq_d.st  = SEQ_COMMIT;
                    seq_d.idx = '0;
                end
            end
            SEQ_COMMIT: begin
                if (seq_q.idx == LAST_SLOT) begin
                    seq_d.st  = SEQ_HOLD;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.idx = seq_q.idx + 1'b1;
                end
            end
            SEQ_HOLD: begin
                if (seq_q.cnt == LAST_CNT) begin
                    seq_d.st = SEQ_IDLE;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            default: seq_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q <= '{st: SEQ_IDLE, idx: '0, cnt: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign idx_o    = seq_q.idx;
    assign commit_o = (seq_q.st == SEQ_COMMIT);
    assign busy_o   = (seq_q.st != SEQ_IDLE);
    assign done_o   = (seq_q.st == SEQ_HOLD) && (seq_q.cnt == LAST_CNT);

    // R5: the commit walk moves up exactly one slot per cycle
    a_r5_slot_ascend: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (commit_o && $past(commit_o)) |-> (idx_o == $past(idx_o) + 1'b1));

    // R6: the hold timer never exceeds its programmed limit
    a_r6_hold_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_q.st == SEQ_HOLD) |-> (seq_q.cnt <= LAST_CNT));

    // R6: a busy period never collapses to a single cycle
    a_r6_busy_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |=> busy_o);
endmodule

// File: rtl/pwb_page_writer.sv
module pwb_page_writer #(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 16,
    parameter int WR_CYCLES  = 500000
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              addr_load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              byte_vld_i,
    input  logic [DATA_W-1:0] byte_i,
    input  logic              stop_i,
    input  logic              wr_allow_i,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_data_o,
    output logic              busy_o
);
    localparam int SLOT_W = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - SLOT_W;

    logic              busy_w, commit_w, done_w, open_w, slot_vld_w;
    logic [SLOT_W-1:0] idx_w;
    logic [PAGE_W-1:0] page_w;
    logic              start_ok, load_ok, byte_ok, stop_ok, go_w;

    assign start_ok = start_i     && !busy_w;
    assign load_ok  = addr_load_i && !busy_w;
    assign byte_ok  = byte_vld_i  && !busy_w;
    assign stop_ok  = stop_i      && !busy_w;
    assign go_w     = stop_ok && open_w;

    pwb_page_latch #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)
    ) u_latch (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clr_i    (start_ok || done_w),
        .load_i   (load_ok),
        .addr_i   (addr_i),
        .wr_i     (byte_ok),
        .data_i   (byte_i),
        .close_i  (stop_ok),
        .rd_idx_i (idx_w),
        .page_o   (page_w),
        .open_o   (open_w),
        .rd_data_o(mem_data_o),
        .rd_vld_o (slot_vld_w)
    );

    pwb_commit_seq #(
        .PAGE_BYTES(PAGE_BYTES), .WR_CYCLES(WR_CYCLES)
    ) u_seq (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .go_i    (go_w),
        .idx_o   (idx_w),
        .commit_o(commit_w),
        .busy_o  (busy_w),
        .done_o  (done_w)
    );

    assign mem_addr_o = {page_w, idx_w};
    assign mem_we_o   = commit_w && slot_vld_w && wr_allow_i;
    assign busy_o     = busy_w;

    // R5: array strobes appear only inside the busy window
    a_r5_we_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_we_o |-> busy_o);

    // R9: the page presented to the array is frozen while busy
    a_r9_page_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && $past(busy_o)) |-> $stable(mem_addr_o[ADDR_W-1:SLOT_W]));

    // R1: no strobe while idle
    a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> !mem_we_o);
endmodule

// File: tb/pwb_page_writer_tb_top.sv
module pwb_page_writer_tb_top;
    localparam int PAGE = 16;
    localparam int WRC  = 24;
    localparam int BUSY_LEN = PAGE + WRC;

    typedef struct packed {
        logic [7:0] addr;
        logic [7:0] nbytes;
        logic [7:0] seed;
        logic       prot;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{8'h30, 8'd4,  8'h11, 1'b0},
        '{8'h3E, 8'd5,  8'h40, 1'b0},
        '{8'h50, 8'd20, 8'h80, 1'b0},
        '{8'h10, 8'd3,  8'h22, 1'b1},
        '{8'hA0, 8'd16, 8'h05, 1'b1},
        '{8'h77, 8'd0,  8'h00, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, addr_load = 1'b0, byte_vld = 1'b0, stop = 1'b0;
    logic [7:0] addr = '0, byte_d = '0;
    logic prot_en = 1'b0;
    logic wr_allow;
    logic mem_we, busy;
    logic [7:0] mem_addr, mem_data;

    always #2 clk = ~clk;

    // protect rule of the bench: lower half blocked when prot_en is set
    assign wr_allow = !(prot_en && !mem_addr[7]);

    pwb_page_writer #(.WR_CYCLES(WRC)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_load_i(addr_load),
        .addr_i(addr), .byte_vld_i(byte_vld), .byte_i(byte_d), .stop_i(stop),
        .wr_allow_i(wr_allow), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_data_o(mem_data), .busy_o(busy)
    );

    int n_checks = 0, n_fail = 0;
    int n_we = 0, n_busy = 0, n_bad = 0, last_lo = -1;
    logic [7:0] mdl [256];
    logic [7:0] exp_mem [256];

    initial begin
        for (int i = 0; i < 256; i++) begin
            mdl[i] = 8'h00;
            exp_mem[i] = 8'h00;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) n_busy++;
            if (mem_we) begin
                n_we++;
                mdl[mem_addr] = mem_data;
                if (!busy) n_bad++;
                if (last_lo >= 0 && int'(mem_addr[3:0]) <= last_lo) n_bad++;
                last_lo = int'(mem_addr[3:0]);
            end
            if (!busy) last_lo = -1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic send_txn(input logic [7:0] a, input int n, input logic [7:0] seed);
        addr_load = 1'b1; addr = a; tick(); addr_load = 1'b0;
        for (int k = 0; k < n; k++) begin
            byte_vld = 1'b1; byte_d = seed + 8'(k * 7); tick();
        end
        byte_vld = 1'b0;
        stop = 1'b1; tick(); stop = 1'b0;
    endtask

    function automatic int mem_mismatch();
        int m = 0;
        for (int i = 0; i < 256; i++) if (mdl[i] !== exp_mem[i]) m++;
        return m;
    endfunction

    function automatic int apply_expected(input logic [7:0] a, input int n,
                                          input logic [7:0] seed, input logic pe);
        logic [7:0] slot_d [PAGE];
        logic [PAGE-1:0] slot_v = '0;
        int cnt = 0;
        for (int k = 0; k < n; k++) begin
            int s = (int'(a[3:0]) + k) % PAGE;
            slot_d[s] = seed + 8'(k * 7);
            slot_v[s] = 1'b1;
        end
        for (int s = 0; s < PAGE; s++) begin
            logic [7:0] ea = {a[7:4], 4'(s)};
            if (slot_v[s] && !(pe && !ea[7])) begin
                exp_mem[ea] = slot_d[s];
                cnt++;
            end
        end
        return cnt;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R1", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int we0, busy0, bad0, exp_we;
        repeat (3) tick();
        // R1: reset state
        chk(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
        chk(mem_we == 1'b0, "R1", "we in reset", int'(mem_we), 0);
        rst_n = 1'b1;
        repeat (4) tick();
        chk(n_we == 0 && busy == 1'b0, "R1", "strobes after reset", n_we, 0);

        // table walk: R2 R3 R4 R6 R7
        for (int v = 0; v < NVEC; v++) begin
            we0 = n_we; busy0 = n_busy; bad0 = n_bad;
            prot_en = VECS[v].prot;
            exp_we = apply_expected(VECS[v].addr, int'(VECS[v].nbytes),
                                    VECS[v].seed, VECS[v].prot);
            send_txn(VECS[v].addr, int'(VECS[v].nbytes), VECS[v].seed);
            repeat (BUSY_LEN + 8) tick();
            chk(mem_mismatch() == 0, "R2/R3", "array contents mismatches",
                mem_mismatch(), 0);
            chk(n_we - we0 == exp_we, "R4/R7", "strobe count", n_we - we0, exp_we);
            chk(n_busy - busy0 == BUSY_LEN, "R6", "busy cycles", n_busy - busy0, BUSY_LEN);
            chk(n_bad == bad0, "R5", "strobe order/window errors", n_bad - bad0, 0);
        end
        prot_en = 1'b0;

        // R6: busy rises the cycle after the stop edge
        addr_load = 1'b1; addr = 8'hE3; tick(); addr_load = 1'b0;
        byte_vld = 1'b1; byte_d = 8'h5A; tick(); byte_vld = 1'b0;
        stop = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R6", "busy before stop edge", int'(busy), 0);
        tick(); stop = 1'b0;
        @(negedge clk);
        chk(busy == 1'b1, "R6", "busy after stop edge", int'(busy), 1);
        exp_mem[8'hE3] = 8'h5A;
        repeat (BUSY_LEN + 8) tick();

        // R8: start discards the open transaction
        we0 = n_we; busy0 = n_busy;
        addr_load = 1'b1; addr = 8'h20; tick(); addr_load = 1'b0;
        for (int k = 0; k < 3; k++) begin byte_vld = 1'b1; byte_d = 8'hF0; tick(); end
        byte_vld = 1'b0;
        start = 1'b1; tick(); start = 1'b0;
        stop = 1'b1; tick(); stop = 1'b0;
        repeat (BUSY_LEN + 8) tick();
        chk(n_busy == busy0, "R8", "busy after discard", n_busy - busy0, 0);
        chk(n_we == we0, "R8", "strobes after discard", n_we - we0, 0);

        // R9: inputs during busy are ignored
        we0 = n_we; busy0 = n_busy;
        addr_load = 1'b1; addr = 8'hB4; tick(); addr_load = 1'b0;
        for (int k = 0; k < 2; k++) begin byte_vld = 1'b1; byte_d = 8'h61 + 8'(k); tick(); end
        byte_vld = 1'b0;
        stop = 1'b1; tick(); stop = 1'b0;
        repeat (3) tick();
        start = 1'b1; tick(); start = 1'b0;
        addr_load = 1'b1; addr = 8'hC0; tick(); addr_load = 1'b0;
        byte_vld = 1'b1; byte_d = 8'h99; tick(); byte_vld = 1'b0;
        stop = 1'b1; tick(); stop = 1'b0;
        repeat (2 * BUSY_LEN + 8) tick();
        exp_mem[8'hB4] = 8'h61;
        exp_mem[8'hB5] = 8'h62;
        chk(n_we - we0 == 2, "R9", "strobes with busy-time inputs", n_we - we0, 2);
        chk(n_busy - busy0 == BUSY_LEN, "R9", "busy cycles with busy-time inputs",
            n_busy - busy0, BUSY_LEN);
        chk(mem_mismatch() == 0, "R9", "array contents", mem_mismatch(), 0);
        chk(mdl[8'hC0] == 8'h00, "R9", "ignored byte at C0", int'(mdl[8'hC0]), 0);

        finish_run();
    end
endmodule